// File: doc/BRIEF.md
# Chip-Select Wait-State Access Sequencer

This block performs a single access to external asynchronous memory on one of four chip selects. A requester presents a chip-select index, an address, a direction flag and write data. Once the sequencer is idle it accepts the request. It looks up the per-chip-select settings: a 4-bit wait code, a write-permission bit and a bus-width code. It then pulls the chosen chip select low, together with either the output-enable strobe or the write strobe, for a stretch of cycles set by the wait code.

When the stretch ends, a one-cycle response pulse returns the data read from the memory, or marks the end of a write. A write aimed at a chip select whose write permission is clear never reaches the memory. No chip select or strobe moves for it, and the response pulse carries an error flag one cycle after the request. The response also reports the width code of the chip select that was used. The block does no packing of narrow data.

Top module: `cs_wait_seq`

## Requirements
- R1: For wait codes 0 to 14, the selected chip select stays low for exactly (code + 2) consecutive cycles, starting in the cycle after acceptance.
- R2: Wait code 15 gives the same access length as code 14, which is 16 cycles.
- R3: During an access, only the bit of `mem_cs_n` whose position equals the request index is low. All chip-select bits are high when no access runs.
- R4: A read holds `mem_oe_n` low and `mem_we_n` high for the whole access. A write holds `mem_we_n` low and `mem_oe_n` high and drives the request data on `mem_wdata`. Both directions drive the request address on `mem_addr` for the whole access.
- R5: `rsp_valid` rises in the cycle after the last low cycle of the chip select. For a read, `rsp_rdata` equals the value `mem_rdata` held in that last low cycle, and `rsp_err` is 0.
- R6: A write to a chip select whose `cfg_wren` bit is 0 is refused. `rsp_valid` and `rsp_err` are both 1 in the cycle after acceptance, and no chip select or strobe goes low.
- R7: `rsp_valid` lasts exactly one cycle. `req_ready` is 1 only while idle, and it returns to 1 in the cycle after the response.
- R8: The wait code, write permission and width code are taken at acceptance. Changing the configuration during an access changes neither its length nor its outcome.
- R9: `rsp_width` returns the 2-bit width code of the selected chip select as sampled at acceptance: 0 means 8 bits, 1 means 16 bits, 2 means 32 bits.
- R10: After reset, `req_ready` is 1, `rsp_valid` is 0 and every chip-select and strobe output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cfg_wait | input | 16 | Wait code of chip select i in bits [4i+3:4i] |
| cfg_wren | input | 4 | Write permission of chip select i in bit i |
| cfg_width | input | 8 | Width code of chip select i in bits [2i+1:2i] |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_cs | input | 2 | Chip-select index |
| req_addr | input | 24 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | 24 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Refused write |
| rsp_rdata | output | 32 | Read data |
| rsp_width | output | 2 | Width code of the accessed chip select |

## Verification
After the accepting edge, the chip select and strobe fall in the very next cycle and stay low for the decoded length L. The response pulse follows one cycle after the last low cycle, which is L+1 cycles after acceptance; a refused write responds after a single cycle. The bench samples at every falling clock edge after acceptance. It counts the low cycles, records the read bus value seen in each one, and demands the response in exactly the expected cycle. It also checks for idle in the cycle after that. The configuration is scrambled in the first cycle after acceptance, so expected values come from a snapshot the bench takes at request time.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DONE   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cs_cfg_select.sv
module cs_cfg_select #(
  parameter int NUM_CS  = 4,
  parameter int WAIT_W  = 4,
  parameter int WIDTH_W = 2,
  parameter int MAX_LEN = 16,
  parameter int CNT_W   = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_CS*WAIT_W-1:0]  cfg_wait,
  input  logic [NUM_CS-1:0]         cfg_wren,
  input  logic [NUM_CS*WIDTH_W-1:0] cfg_width,
  input  logic [SEL_W-1:0]          sel,
  output logic [CNT_W-1:0]          len_m1,
  output logic                      wr_ok,
  output logic [WIDTH_W-1:0]        width
);
  localparam int EXT_W = WAIT_W + 1;

  logic [WAIT_W-1:0]  wait_arr  [NUM_CS];
  logic [WIDTH_W-1:0] width_arr [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_unpack
    assign wait_arr[i]  = cfg_wait[i*WAIT_W +: WAIT_W];
    assign width_arr[i] = cfg_width[i*WIDTH_W +: WIDTH_W];
  end

  logic [EXT_W-1:0] code_p1;

  always_comb begin
    code_p1 = {1'b0, wait_arr[sel]} + EXT_W'(1);
    if (code_p1 > EXT_W'(MAX_LEN - 1)) begin
      len_m1 = CNT_W'(MAX_LEN - 1);
    end else begin
      len_m1 = CNT_W'(code_p1);
    end
    wr_ok = cfg_wren[sel];
    width = width_arr[sel];
  end
endmodule

// File: rtl/cs_len_counter.sv
module cs_len_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (en && (cnt_q != '0)) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/cs_wait_seq.sv
module cs_wait_seq #(
  parameter int NUM_CS  = 4,
  parameter int WAIT_W  = 4,
  parameter int WIDTH_W = 2,
  parameter int MAX_LEN = 16,
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  localparam int SEL_W  = $clog2(NUM_CS),
  localparam int CNT_W  = $clog2(MAX_LEN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CS*WAIT_W-1:0]  cfg_wait,
  input  logic [NUM_CS-1:0]         cfg_wren,
  input  logic [NUM_CS*WIDTH_W-1:0] cfg_width,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [SEL_W-1:0]          req_cs,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_write,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic [NUM_CS-1:0]         mem_cs_n,
  output logic                      mem_oe_n,
  output logic                      mem_we_n,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic                      rsp_valid,
  output logic                      rsp_err,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic [WIDTH_W-1:0]        rsp_width
);
  import cs_seq_pkg::*;

  seq_state_e state_q, state_d;

  logic [CNT_W-1:0]   sel_len_m1;
  logic               sel_wr_ok;
  logic [WIDTH_W-1:0] sel_width;
  logic               accept, refuse, active, last;

  logic [SEL_W-1:0]   cs_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               wr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [WIDTH_W-1:0] width_q;
  logic               err_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               rd_cap;

  cs_cfg_select #(
    .NUM_CS(NUM_CS), .WAIT_W(WAIT_W), .WIDTH_W(WIDTH_W),
    .MAX_LEN(MAX_LEN), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_cfg (
    .cfg_wait (cfg_wait),
    .cfg_wren (cfg_wren),
    .cfg_width(cfg_width),
    .sel      (req_cs),
    .len_m1   (sel_len_m1),
    .wr_ok    (sel_wr_ok),
    .width    (sel_width)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign refuse    = req_write && !sel_wr_ok;
  assign active    = (state_q == ST_ACTIVE);
  assign rd_cap    = active && last && !wr_q;

  cs_len_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_val(sel_len_m1),
    .en      (active),
    .last    (last)
  );

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = refuse ? ST_DONE : ST_ACTIVE;
      ST_ACTIVE: if (last) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // request capture, enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      width_q <= '0;
      err_q   <= 1'b0;
    end else if (accept) begin
      cs_q    <= req_cs;
      addr_q  <= req_addr;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
      width_q <= sel_width;
      err_q   <= refuse;
    end
  end

  // read capture on the final active cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_cap) rdata_q <= mem_rdata;
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign mem_cs_n[i] = !(active && (cs_q == SEL_W'(i)));
  end

  assign mem_oe_n  = !(active && !wr_q);
  assign mem_we_n  = !(active && wr_q);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
  assign rsp_width = width_q;
endmodule

// File: rtl/cs_wait_seq_chk.sv
module cs_wait_seq_chk #(
  parameter int NUM_CS  = 4,
  parameter int WAIT_W  = 4,
  parameter int MAX_LEN = 16,
  parameter int SEL_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CS*WAIT_W-1:0] cfg_wait,
  input logic [NUM_CS-1:0]        cfg_wren,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [SEL_W-1:0]         req_cs,
  input logic                     req_write,
  input logic [NUM_CS-1:0]        mem_cs_n,
  input logic                     mem_oe_n,
  input logic                     mem_we_n,
  input logic                     rsp_valid,
  input logic                     rsp_err
);
  localparam int RUN_W = $clog2(MAX_LEN + 2) + 1;

  logic             acc;
  logic [WAIT_W-1:0] code;
  logic [RUN_W-1:0] exp_len_q, run_q;

  assign acc  = req_valid && req_ready;
  assign code = cfg_wait[req_cs*WAIT_W +: WAIT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_len_q <= '0;
      run_q     <= '0;
    end else begin
      if (acc) begin
        if (RUN_W'(code) + RUN_W'(2) > RUN_W'(MAX_LEN)) exp_len_q <= RUN_W'(MAX_LEN);
        else                                           exp_len_q <= RUN_W'(code) + RUN_W'(2);
      end
      if (mem_cs_n != '1) run_q <= run_q + RUN_W'(1);
      else                run_q <= '0;
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n)); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R4

  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1)); // R4

  AST_ACCESS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&mem_cs_n) |-> (run_q == exp_len_q)); // R1

  AST_REFUSED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !cfg_wren[req_cs]) |=>
      (mem_cs_n == '1 && mem_we_n && rsp_valid && rsp_err)); // R6

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n != '1 || rsp_valid) |-> !req_ready); // R7
endmodule

bind cs_wait_seq cs_wait_seq_chk #(
  .NUM_CS(NUM_CS), .WAIT_W(WAIT_W), .MAX_LEN(MAX_LEN), .SEL_W(SEL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wait (cfg_wait),
  .cfg_wren (cfg_wren),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_cs   (req_cs),
  .req_write(req_write),
  .mem_cs_n (mem_cs_n),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .rsp_valid(rsp_valid),
  .rsp_err  (rsp_err)
);

// File: tb/tb_cs_wait_seq.sv
module tb_cs_wait_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_wait;
  logic [3:0]  cfg_wren;
  logic [7:0]  cfg_width;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_cs = '0;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_width;

  logic [3:0] c_wait  [4];
  logic       c_wren  [4];
  logic [1:0] c_width [4];
  logic [31:0] cyc = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 32'd1;
  always_comb mem_rdata = (cyc * 32'h9E3779B1) ^ 32'h5A5A0000;

  for (genvar i = 0; i < 4; i++) begin : g_cfg
    assign cfg_wait[4*i +: 4]  = c_wait[i];
    assign cfg_wren[i]         = c_wren[i];
    assign cfg_width[2*i +: 2] = c_width[i];
  end

  cs_wait_seq dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [3:0] code);
    return (code == 4'd15) ? 16 : int'(code) + 2;
  endfunction

  task automatic scramble_cfg();
    for (int i = 0; i < 4; i++) begin
      c_wait[i]  = 4'($urandom);
      c_wren[i]  = 1'($urandom);
      c_width[i] = 2'($urandom_range(0, 2));
    end
  endtask

  task automatic access(input logic [1:0] cs, input logic [23:0] addr, input bit wr,
                        input logic [31:0] wd, input bit shake);
    int L, act_n, rsp_at;
    bit refused;
    logic [1:0] ew;
    logic [31:0] last_rd;
    @(negedge clk);
    L = exp_len(c_wait[cs]);
    refused = wr && !c_wren[cs];
    ew = c_width[cs];
    check(req_ready === 1'b1, "R7 ready when idle", 32'(req_ready), 1);
    req_valid = 1'b1; req_cs = cs; req_addr = addr; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~addr; req_wdata = ~wd;
    if (shake) scramble_cfg(); // R8: changes after acceptance must not matter
    act_n = 0; rsp_at = -1; last_rd = '0;
    for (int i = 0; i < 40; i++) begin
      if (rsp_valid) begin rsp_at = i; break; end
      if (mem_cs_n != 4'hF) begin
        act_n++;
        last_rd = mem_rdata;
        check(mem_cs_n == ~(4'b1 << cs), "R3 cs line", 32'(mem_cs_n), 32'(~(4'b1 << cs)));
        check(mem_oe_n == wr && mem_we_n == !wr, "R4 strobes",
              {30'b0, mem_oe_n, mem_we_n}, {30'b0, wr, !wr});
        check(mem_addr == addr, "R4 address", 32'(mem_addr), 32'(addr));
        if (wr) check(mem_wdata == wd, "R4 write data", mem_wdata, wd);
      end else begin
        check(mem_oe_n && mem_we_n, "R6 no strobe without cs", {30'b0, mem_oe_n, mem_we_n}, 3);
      end
      @(negedge clk);
    end
    if (refused) begin
      check(act_n == 0, "R6 no bus activity", act_n, 0);
      check(rsp_at == 0, "R6 error response timing", rsp_at, 0);
      check(rsp_err == 1'b1, "R6 error flag", 32'(rsp_err), 1);
    end else begin
      check(act_n == L, (c_wait[cs] == 15 && !shake) ? "R2 saturated length" : "R1 access length", act_n, L);
      check(rsp_at == L, "R5 response timing", rsp_at, L);
      check(rsp_err == 1'b0, "R5 no error", 32'(rsp_err), 0);
      if (!wr) check(rsp_rdata == last_rd, "R5 read data", rsp_rdata, last_rd);
    end
    check(rsp_width == ew, "R9 width code", 32'(rsp_width), 32'(ew));
    @(negedge clk);
    check(!rsp_valid && req_ready, "R7 single pulse and idle", {30'b0, rsp_valid, req_ready}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 4; i++) begin
      c_wait[i] = 4'(i); c_wren[i] = 1'b1; c_width[i] = 2'(i % 3);
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(req_ready && !rsp_valid && mem_cs_n == 4'hF && mem_oe_n && mem_we_n,
          "R10 reset state", {25'b0, req_ready, rsp_valid, mem_cs_n, mem_oe_n}, 32'h5F);
    rst_n = 1'b1;
    // R1/R2: every code, reads
    for (int k = 0; k < 16; k++) begin
      c_wait[k % 4] = 4'(k);
      access(2'(k % 4), 24'(k * 24'h1111), 1'b0, 32'h0, 1'b0);
    end
    // R6: refused write, then allowed write
    c_wren[2] = 1'b0;
    access(2'd2, 24'hABCDEF, 1'b1, 32'hDEADBEEF, 1'b0);
    c_wren[1] = 1'b1; c_wait[1] = 4'd15;
    access(2'd1, 24'h00F00D, 1'b1, 32'hCAFEF00D, 1'b0);
    // R8: change config during a saturated access
    c_wait[3] = 4'd15; c_wren[3] = 1'b1;
    access(2'd3, 24'h123456, 1'b0, 32'h0, 1'b1);
    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      scramble_cfg();
      access(2'($urandom), 24'($urandom), 1'($urandom), $urandom, 1'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule